// File: doc/BRIEF.md
# Serial Flash SPI Master with Byte FIFOs

This block is a register-programmed SPI master for driving a serial flash device under software control. A processor pushes transmit bytes into an 8-entry transmit queue and pops received bytes from an 8-entry receive queue. Both queues, and the rest of the configuration, sit behind a single 32-bit register port. A shift engine turns each queued byte into one frame on the serial clock, output data and input data pins. Clock divider, polarity, phase, bit order, direction and frame length are all programmable.

A group of chip-select lines is driven according to a select mode. In auto mode the line is released after every frame. In hold mode it is kept asserted so that a multi-byte command goes out under one select. In off mode it is never asserted. Software polls the top bit of the data registers for full and empty status. Two level flags, compared against programmable thresholds, raise an interrupt request when enabled.

Top module: `spim_top`

## Requirements
- R1: After reset the registers read: divider (offset 0x00) = 3, clock mode (0x04) = 0, select index (0x10) = 0, select idle levels (0x14) = all ones, select mode (0x18) = 0, format (0x40) = 0x0008_0008 (single lane, MSB first, transmit, 8 bits). All select outputs are high and the serial clock is low. A written divider value reads back.
- R2: The serial clock idles at the level of clock-mode bit 0 (polarity). Within a frame, every clock half-period lasts divider+1 system clocks.
- R3: Format bits [19:16] give the frame length N (1..8; 0 or above 8 means 8). Bit 2 selects LSB first (1) or MSB first (0). MSB first sends byte bit N-1 first and places the first received bit at N-1. LSB first uses bit 0 first. Clock-mode bit 1 = 0 samples input on the leading edge, and bit 1 = 1 samples it on the trailing edge. The sent bits and received byte are correct for all four clock modes.
- R4: With format bit 3 = 0 (receive), each frame pushes the sampled input byte into the receive queue. With bit 3 = 1 (transmit), received bits are discarded.
- R5: In select mode 0 (auto), the select line is released after each frame. It stays released for at least two clock half-periods (2*(divider+1) clocks) before the next frame starts.
- R6: In select mode 2 (hold), the select line stays asserted across back-to-back frames. It is released once the mode changes to auto.
- R7: In select mode 3 (off), no select line is ever asserted, and each output equals its bit of the idle-level register. Frames are still sent.
- R8: Only the line chosen by the select index register is asserted, by driving it to the inverse of its idle level. At most one line is asserted at a time.
- R9: A read of the transmit data register (0x48) returns bit 31 = 1 when the 8-entry transmit queue is full, and 0 otherwise. A write stores bits [7:0] as one frame. A write to a full queue is ignored.
- R10: A read of the receive data register (0x4C) returns bit 31 = 1 when the receive queue is empty. Otherwise it returns the oldest byte in bits [7:0] and pops it.
- R11: Interrupt-pending (0x74) bit 0 is set while the transmit count is below transmit-control (0x50) bits [15:0]. Bit 1 is set while the receive count is above receive-control (0x54) bits [15:0]. The interrupt output is the OR of pending bits masked by interrupt-enable (0x70) bits [1:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_en | input | 1 | Register access strobe |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid in the strobe cycle |
| irq | output | 1 | Interrupt request |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | NCS | Chip-select lines |

## Verification
The bench models a serial device that shifts a known byte out and records what it receives. It sweeps polarity, phase, bit order and a short and a full frame length. A design that shifts on the wrong edge, or packs short frames at the wrong end, shows up as a shifted or mirrored byte. Edge spacing and select gaps are measured in clocks: a divider off by one, or an auto-mode gap cut to zero, would break the counts. Overfilling the transmit queue must yield exactly nine frames, so a queue that accepts writes when full produces extra frames. The hold, off and index cases catch a select line that pulses between frames, asserts in off mode, or drives the wrong line.

// File: rtl/spim_pkg.sv
package spim_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_GAP  = 2'd2
  } eng_st_e;

  localparam logic [1:0] CSM_AUTO = 2'd0;
  localparam logic [1:0] CSM_HOLD = 2'd2;
  localparam logic [1:0] CSM_OFF  = 2'd3;

  localparam logic [7:0] A_DIV   = 8'h00;
  localparam logic [7:0] A_MODE  = 8'h04;
  localparam logic [7:0] A_CSID  = 8'h10;
  localparam logic [7:0] A_CSDEF = 8'h14;
  localparam logic [7:0] A_CSM   = 8'h18;
  localparam logic [7:0] A_FMT   = 8'h40;
  localparam logic [7:0] A_TXD   = 8'h48;
  localparam logic [7:0] A_RXD   = 8'h4C;
  localparam logic [7:0] A_TXC   = 8'h50;
  localparam logic [7:0] A_RXC   = 8'h54;
  localparam logic [7:0] A_IE    = 8'h70;
  localparam logic [7:0] A_IP    = 8'h74;
endpackage

// File: rtl/spim_fifo.sv
module spim_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 8,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [W-1:0]  wdata,
  input  logic          pop,
  output logic [W-1:0]  rdata,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp_q, rp_q, wp_d, rp_d;
  logic [CW-1:0] cnt_d;
  logic          do_push, do_pop;

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign do_push = push & ~full;
  assign do_pop  = pop & ~empty;
  assign rdata   = mem[rp_q];

  always_comb begin
    wp_d  = wp_q;
    rp_d  = rp_q;
    cnt_d = count;
    if (do_push) wp_d = (wp_q == AW'(DEPTH - 1)) ? '0 : wp_q + AW'(1);
    if (do_pop)  rp_d = (rp_q == AW'(DEPTH - 1)) ? '0 : rp_q + AW'(1);
    if (do_push && !do_pop) cnt_d = count + CW'(1);
    else if (do_pop && !do_push) cnt_d = count - CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      count <= '0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      count <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wp_q] <= wdata;
  end
endmodule

// File: rtl/spim_shift.sv
module spim_shift
  import spim_pkg::*;
#(
  parameter int DIVW = 12,
  parameter int BW   = 8,
  localparam int NBW = $clog2(BW + 1),
  localparam int HW  = NBW + 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [BW-1:0]   tx_byte,
  input  logic [DIVW-1:0] div,
  input  logic            cpha,
  input  logic            lsb_first,
  input  logic [3:0]      len,
  input  logic            auto_gap,
  input  logic            miso,
  output logic            busy,
  output logic            in_frame,
  output logic            done,
  output logic [BW-1:0]   rx_byte,
  output logic            sck_ph,
  output logic            mosi
);
  eng_st_e         st_q, st_d;
  logic [DIVW-1:0] cnt_q, cnt_d;
  logic [HW-1:0]   half_q, half_d, last_half;
  logic [BW-1:0]   txsr_q, txsr_d, rxsr_q, rxsr_d, rx_shift, rxo_d;
  logic [NBW-1:0]  nb_q, nb_d, nb_sel;
  logic            lsb_q, lsb_d, cpha_q, cpha_d, ph_d, done_d, tick;

  assign nb_sel    = (len == 4'd0 || 32'(len) > BW) ? NBW'(BW) : NBW'(len);
  assign last_half = HW'({nb_q, 1'b0}) - HW'(1);
  assign tick      = (cnt_q == div);
  assign busy      = (st_q != ST_IDLE);
  assign in_frame  = (st_q == ST_RUN);
  assign mosi      = lsb_q ? txsr_q[0] : txsr_q[nb_q - NBW'(1)];
  assign rx_shift  = lsb_q ? ((rxsr_q >> 1) | (BW'(miso) << (nb_q - NBW'(1))))
                           : {rxsr_q[BW-2:0], miso};

  always_comb begin
    st_d = st_q; cnt_d = cnt_q; half_d = half_q; txsr_d = txsr_q; rxsr_d = rxsr_q;
    nb_d = nb_q; lsb_d = lsb_q; cpha_d = cpha_q; ph_d = sck_ph; done_d = 1'b0;
    rxo_d = rx_byte;
    case (st_q)
      ST_IDLE: begin
        cnt_d = '0; half_d = '0; ph_d = 1'b0;
        if (start) begin
          st_d = ST_RUN; txsr_d = tx_byte; rxsr_d = '0;
          nb_d = nb_sel; lsb_d = lsb_first; cpha_d = cpha;
        end
      end
      ST_RUN: begin
        if (tick) begin
          cnt_d = '0;
          ph_d  = ~sck_ph;
          if (half_q[0] == cpha_q) rxsr_d = rx_shift;
          if (half_q[0] != cpha_q && !(cpha_q && half_q == '0))
            txsr_d = lsb_q ? (txsr_q >> 1) : (txsr_q << 1);
          if (half_q == last_half) begin
            done_d = 1'b1;
            rxo_d  = rxsr_d;
            half_d = '0;
            st_d   = auto_gap ? ST_GAP : ST_IDLE;
          end else begin
            half_d = half_q + HW'(1);
          end
        end else begin
          cnt_d = cnt_q + DIVW'(1);
        end
      end
      default: begin
        if (tick) begin
          cnt_d = '0;
          if (half_q[0]) begin st_d = ST_IDLE; half_d = '0; end
          else half_d = HW'(1);
        end else begin
          cnt_d = cnt_q + DIVW'(1);
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE; cnt_q <= '0; half_q <= '0; txsr_q <= '0; rxsr_q <= '0;
      nb_q <= NBW'(BW); lsb_q <= 1'b0; cpha_q <= 1'b0; sck_ph <= 1'b0;
      done <= 1'b0; rx_byte <= '0;
    end else begin
      st_q <= st_d; cnt_q <= cnt_d; half_q <= half_d; txsr_q <= txsr_d; rxsr_q <= rxsr_d;
      nb_q <= nb_d; lsb_q <= lsb_d; cpha_q <= cpha_d; sck_ph <= ph_d;
      done <= done_d; rx_byte <= rxo_d;
    end
  end
endmodule

// File: rtl/spim_top.sv
module spim_top
  import spim_pkg::*;
#(
  parameter int NCS   = 2,
  parameter int DIVW  = 12,
  parameter int DEPTH = 8,
  parameter int WMW   = 16,
  localparam int IDW  = (NCS > 1) ? $clog2(NCS) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           reg_en,
  input  logic           reg_we,
  input  logic [7:0]     reg_addr,
  input  logic [31:0]    reg_wdata,
  output logic [31:0]    reg_rdata,
  output logic           irq,
  output logic           sck,
  output logic           mosi,
  input  logic           miso,
  output logic [NCS-1:0] cs_n
);
  logic [DIVW-1:0] div_q;
  logic            cpol_q, cpha_q, lsb_q, dir_q, hold_q;
  logic [IDW-1:0]  csid_q;
  logic [NCS-1:0]  csdef_q;
  logic [1:0]      csmode_q, proto_q, ie_q, ip;
  logic [3:0]      len_q;
  logic [WMW-1:0]  txwm_q, rxwm_q;
  logic            wr, tx_push, rx_rd, tx_full, tx_empty, rx_full, rx_empty;
  logic            eng_busy, eng_frame, eng_done, eng_start, sck_ph, cs_act;
  logic [7:0]      tx_dout, rx_dout, eng_rx;
  logic [CW-1:0]   tx_cnt, rx_cnt;
  logic            unused_ok;

  assign unused_ok = &{1'b0, reg_wdata[31:20], rx_full};
  assign wr        = reg_en & reg_we;
  assign tx_push   = wr & (reg_addr == A_TXD);
  assign rx_rd     = reg_en & ~reg_we & (reg_addr == A_RXD);
  assign eng_start = ~eng_busy & ~tx_empty;

  spim_fifo #(.W(8), .DEPTH(DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_n), .push(tx_push), .wdata(reg_wdata[7:0]), .pop(eng_start),
    .rdata(tx_dout), .count(tx_cnt), .full(tx_full), .empty(tx_empty));

  spim_fifo #(.W(8), .DEPTH(DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_n), .push(eng_done & ~dir_q), .wdata(eng_rx), .pop(rx_rd),
    .rdata(rx_dout), .count(rx_cnt), .full(rx_full), .empty(rx_empty));

  spim_shift #(.DIVW(DIVW), .BW(8)) u_eng (
    .clk(clk), .rst_n(rst_n), .start(eng_start), .tx_byte(tx_dout), .div(div_q),
    .cpha(cpha_q), .lsb_first(lsb_q), .len(len_q), .auto_gap(csmode_q != CSM_HOLD),
    .miso(miso), .busy(eng_busy), .in_frame(eng_frame), .done(eng_done),
    .rx_byte(eng_rx), .sck_ph(sck_ph), .mosi(mosi));

  assign sck    = sck_ph ^ cpol_q;
  assign cs_act = (csmode_q != CSM_OFF) &
                  (eng_frame | ((csmode_q == CSM_HOLD) & hold_q));

  for (genvar i = 0; i < NCS; i++) begin : g_cs
    assign cs_n[i] = (cs_act && csid_q == IDW'(i)) ? ~csdef_q[i] : csdef_q[i];
  end

  assign ip  = {(WMW'(rx_cnt) > rxwm_q), (WMW'(tx_cnt) < txwm_q)};
  assign irq = |(ip & ie_q);

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_DIV:   reg_rdata = 32'(div_q);
      A_MODE:  reg_rdata = {30'b0, cpha_q, cpol_q};
      A_CSID:  reg_rdata = 32'(csid_q);
      A_CSDEF: reg_rdata = 32'(csdef_q);
      A_CSM:   reg_rdata = {30'b0, csmode_q};
      A_FMT:   reg_rdata = {12'b0, len_q, 12'b0, dir_q, lsb_q, proto_q};
      A_TXD:   reg_rdata = {tx_full, 31'b0};
      A_RXD:   reg_rdata = rx_empty ? 32'h8000_0000 : {24'b0, rx_dout};
      A_TXC:   reg_rdata = 32'(txwm_q);
      A_RXC:   reg_rdata = 32'(rxwm_q);
      A_IE:    reg_rdata = {30'b0, ie_q};
      A_IP:    reg_rdata = {30'b0, ip};
      default: reg_rdata = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= DIVW'(3); cpol_q <= 1'b0; cpha_q <= 1'b0; csid_q <= '0;
      csdef_q <= '1; csmode_q <= CSM_AUTO; proto_q <= '0; lsb_q <= 1'b0;
      dir_q <= 1'b1; len_q <= 4'd8; txwm_q <= '0; rxwm_q <= '0; ie_q <= '0;
      hold_q <= 1'b0;
    end else begin
      if (wr) begin
        case (reg_addr)
          A_DIV:   div_q <= reg_wdata[DIVW-1:0];
          A_MODE:  {cpha_q, cpol_q} <= reg_wdata[1:0];
          A_CSID:  csid_q <= reg_wdata[IDW-1:0];
          A_CSDEF: csdef_q <= reg_wdata[NCS-1:0];
          A_CSM:   csmode_q <= reg_wdata[1:0];
          A_FMT:   {len_q, dir_q, lsb_q, proto_q} <= {reg_wdata[19:16], reg_wdata[3:0]};
          A_TXC:   txwm_q <= reg_wdata[WMW-1:0];
          A_RXC:   rxwm_q <= reg_wdata[WMW-1:0];
          A_IE:    ie_q <= reg_wdata[1:0];
          default: ;
        endcase
      end
      if (csmode_q != CSM_HOLD) hold_q <= 1'b0;
      else if (eng_start)       hold_q <= 1'b1;
    end
  end
endmodule

// File: rtl/spim_chk.sv
module spim_chk #(
  parameter int NCS   = 2,
  parameter int DEPTH = 8,
  parameter int CW    = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic [1:0]     csmode,
  input logic [NCS-1:0] csdef,
  input logic [NCS-1:0] cs_n,
  input logic           cpol,
  input logic           sck,
  input logic           eng_busy,
  input logic           tx_push,
  input logic           tx_pop,
  input logic           tx_full,
  input logic [CW-1:0]  tx_cnt,
  input logic           rx_rd,
  input logic           rx_empty,
  input logic [31:0]    rdata
);
  // R7
  off_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (csmode == 2'd3) |-> (cs_n == csdef));

  // R8
  one_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(cs_n ^ csdef) <= 1);

  // R2
  sck_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !eng_busy |-> (sck == cpol));

  // R9
  tx_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_full && tx_push && !tx_pop) |=> (tx_cnt == $past(tx_cnt)));

  // R9
  tx_depth_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_cnt <= CW'(DEPTH));

  // R10
  rx_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_rd && rx_empty) |-> rdata[31]);
endmodule

bind spim_top spim_chk #(.NCS(NCS), .DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .csmode(csmode_q), .csdef(csdef_q), .cs_n(cs_n),
  .cpol(cpol_q), .sck(sck), .eng_busy(eng_busy), .tx_push(tx_push),
  .tx_pop(eng_start), .tx_full(tx_full), .tx_cnt(tx_cnt), .rx_rd(rx_rd),
  .rx_empty(rx_empty), .rdata(reg_rdata));

// File: tb/sim_spim_top.sv
module sim_spim_top;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_en = 1'b0, reg_we = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq, sck, mosi, miso;
  logic [1:0]  cs_n;

  int checks = 0, errors = 0;
  int e = 0, nb_b = 8, frames = 0, kk2;
  logic cpha_b = 1'b0, lsb_b = 1'b0;
  logic [7:0] pat = 8'h00, rec = 8'h00;
  logic sck_prev = 1'b0, cs0_prev = 1'b1;
  int since_edge = 0, min_sp = 1000, max_sp = 0;
  int rises = 0, falls = 0, hi_run = 0, min_gap = 1000;
  logic low0_seen = 1'b0, low1_seen = 1'b0;

  spim_top u0 (
    .clk(clk), .rst_n(rst_n), .reg_en(reg_en), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq), .sck(sck), .mosi(mosi),
    .miso(miso), .cs_n(cs_n));

  always #(CLK_P/2) clk = ~clk;

  // serial device model: drives pattern bit k, records sampled mosi
  always_comb begin
    kk2 = cpha_b ? ((e == 0) ? 0 : (e - 1) / 2) : e / 2;
    miso = lsb_b ? pat[kk2] : pat[nb_b - 1 - kk2];
  end

  always @(negedge clk) begin
    if (rst_n) begin
      since_edge++;
      if (sck !== sck_prev) begin
        if (e != 0) begin
          if (since_edge < min_sp) min_sp = since_edge;
          if (since_edge > max_sp) max_sp = since_edge;
        end
        since_edge = 0;
        if ((e % 2) == (cpha_b ? 1 : 0)) begin
          if (lsb_b) rec[e/2] = mosi;
          else       rec[nb_b - 1 - e/2] = mosi;
        end
        e++;
        if (e == 2 * nb_b) begin e = 0; frames++; end
      end
      sck_prev = sck;
      if (cs_n[0] && !cs0_prev) rises++;
      if (!cs_n[0] && cs0_prev) begin
        falls++;
        if (hi_run > 0 && hi_run < min_gap) min_gap = hi_run;
      end
      hi_run = cs_n[0] ? hi_run + 1 : 0;
      cs0_prev = cs_n[0];
      if (!cs_n[0]) low0_seen = 1'b1;
      if (!cs_n[1]) low1_seen = 1'b1;
    end
  end

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", r, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_en = 1'b1; reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_en = 1'b0; reg_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_en = 1'b1; reg_we = 1'b0; reg_addr = a;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_en = 1'b0;
  endtask

  task automatic resync();
    @(posedge clk); #1;
    e = 0; sck_prev = sck; since_edge = 0; rec = 8'h00;
  endtask

  task automatic cfg(input logic cpol, input logic cpha, input logic lsb,
                     input logic dir, input int len);
    wr(8'h04, {30'b0, cpha, cpol});
    wr(8'h40, (32'(len) << 16) | (32'(dir) << 3) | (32'(lsb) << 2));
    cpha_b = cpha; lsb_b = lsb; nb_b = len;
    resync();
  endtask

  task automatic wait_frames(input int target);
    int n = 0;
    while (frames < target && n < 20000) begin @(posedge clk); n++; end
    repeat (60) @(posedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int f0, r0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1 reset values
    rd(8'h00, d); chk("R1 div", d, 32'd3);
    rd(8'h04, d); chk("R1 mode", d, 32'd0);
    rd(8'h10, d); chk("R1 csid", d, 32'd0);
    rd(8'h14, d); chk("R1 csdef", d, 32'd3);
    rd(8'h18, d); chk("R1 csmode", d, 32'd0);
    rd(8'h40, d); chk("R1 fmt", d, 32'h0008_0008);
    chk("R1 cs_n", {30'b0, cs_n}, 32'd3);
    chk("R1 sck", {31'b0, sck}, 32'd0);
    rd(8'h74, d); chk("R11 ip reset", d, 32'd0);
    rd(8'h4C, d); chk("R10 rx empty", d, 32'h8000_0000);
    rd(8'h48, d); chk("R9 tx not full", d, 32'd0);
    wr(8'h00, 32'd1);
    rd(8'h00, d); chk("R1 div readback", d, 32'd1);

    // R3 sweep of clock mode, bit order and length, receive direction (R4)
    for (int c = 0; c < 16; c++) begin
      logic [7:0] t, m;
      int len;
      len = c[3] ? 5 : 8;
      m = 8'((1 << len) - 1);
      t = 8'hA5 ^ 8'(c * 37);
      pat = 8'h3C + 8'(c * 29);
      cfg(c[0], c[1], c[2], 1'b0, len);
      chk("R2 idle level", {31'b0, sck}, {31'b0, c[0]});
      f0 = frames;
      wr(8'h48, {24'b0, t});
      wait_frames(f0 + 1);
      chk("R3 sent bits", {24'b0, rec}, {24'b0, t & m});
      rd(8'h4C, d); chk("R3 R4 received byte", d, {24'b0, pat & m});
    end

    // R2 half period, R5 auto gap, R4 transmit discards
    wr(8'h00, 32'd2);
    cfg(1'b0, 1'b0, 1'b0, 1'b1, 8);
    min_sp = 1000; max_sp = 0; min_gap = 1000;
    f0 = frames;
    wr(8'h48, 32'h11); wr(8'h48, 32'h22); wr(8'h48, 32'h33);
    wait_frames(f0 + 3);
    chk("R2 min half period", min_sp, 32'd3);
    chk("R2 max half period", max_sp, 32'd3);
    chk("R5 gap >= 6", {31'b0, (min_gap >= 6)}, 32'd1);
    rd(8'h4C, d); chk("R4 transmit discards", d, 32'h8000_0000);

    // R6 hold mode
    wr(8'h18, 32'd2);
    r0 = rises; f0 = frames;
    wr(8'h48, 32'h44); wr(8'h48, 32'h55);
    wait_frames(f0 + 2);
    chk("R6 no release", rises, r0);
    chk("R6 still asserted", {31'b0, cs_n[0]}, 32'd0);
    wr(8'h18, 32'd0);
    repeat (2) @(posedge clk); #1;
    chk("R6 released", {30'b0, cs_n}, 32'd3);

    // R7 off mode and idle levels
    wr(8'h18, 32'd3);
    r0 = falls; f0 = frames;
    wr(8'h48, 32'h66);
    wait_frames(f0 + 1);
    chk("R7 never asserted", falls, r0);
    chk("R7 frame sent", frames, f0 + 1);
    wr(8'h14, 32'd1);
    @(negedge clk);
    chk("R7 idle levels", {30'b0, cs_n}, 32'd1);
    wr(8'h14, 32'd3);
    wr(8'h18, 32'd0);

    // R8 select index
    wr(8'h10, 32'd1);
    low0_seen = 1'b0; low1_seen = 1'b0; f0 = frames;
    wr(8'h48, 32'h77);
    wait_frames(f0 + 1);
    chk("R8 line1 asserted", {31'b0, low1_seen}, 32'd1);
    chk("R8 line0 untouched", {31'b0, low0_seen}, 32'd0);
    wr(8'h10, 32'd0);

    // R9 full queue, extra writes ignored
    wr(8'h00, 32'd20);
    f0 = frames;
    for (int i = 0; i < 12; i++) wr(8'h48, 32'(i));
    rd(8'h48, d); chk("R9 full flag", d, 32'h8000_0000);
    wait_frames(f0 + 9);
    repeat (400) @(posedge clk);
    chk("R9 frame count", frames - f0, 32'd9);
    rd(8'h48, d); chk("R9 not full after drain", d, 32'd0);

    // R11 watermarks and irq, R10 pop order
    wr(8'h00, 32'd1);
    pat = 8'h5A;
    cfg(1'b0, 1'b0, 1'b0, 1'b0, 8);
    wr(8'h50, 32'd1);
    rd(8'h74, d); chk("R11 tx mark", d, 32'd1);
    wr(8'h50, 32'd0);
    wr(8'h54, 32'd1);
    f0 = frames;
    wr(8'h48, 32'h01); wr(8'h48, 32'h02);
    wait_frames(f0 + 2);
    rd(8'h74, d); chk("R11 rx mark above", d, 32'd2);
    chk("R11 irq masked", {31'b0, irq}, 32'd0);
    wr(8'h70, 32'd2);
    @(negedge clk);
    chk("R11 irq enabled", {31'b0, irq}, 32'd1);
    wr(8'h54, 32'd2);
    rd(8'h74, d); chk("R11 rx mark equal", d, 32'd0);
    @(negedge clk);
    chk("R11 irq clear", {31'b0, irq}, 32'd0);
    rd(8'h4C, d); chk("R10 first pop", d, 32'h5A);
    rd(8'h4C, d); chk("R10 second pop", d, 32'h5A);
    rd(8'h4C, d); chk("R10 empty after pops", d, 32'h8000_0000);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule